// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer with a 9-bit word and a depth set by parameter (256, 512, 1024, 2048, 4096 or 8192 words, 2048 by default). The write side and the read side each run on their own free-running clock. The two clocks may be one net or fully unrelated. A word is stored only when both write enables are high. A word is removed only when both read enables are high. Read data is registered, so a word appears one read clock after the edge that accepted it.

Four status outputs report fill level. Empty and almost-empty are computed in the read clock domain. Full and almost-full are computed in the write clock domain. Each domain sees the other side's pointer through a Gray-coded two-flop synchroniser. Both thresholds are 7 after reset and can be reprogrammed through the write port. While the load input is high, every enabled write puts a byte into the next threshold register instead of into the buffer.

The read-side enable is modelled as a valid indicator rather than a three-state driver.

Top module: `async_fifo_thr`

## Requirements
- R1: A word is stored on a write-clock edge only when `wen_a_i` and `wen_b_i` are both 1 and `load_i` is 0. With either write enable low, nothing is stored.
- R2: A word is removed on a read-clock edge only when `ren_a_i` and `ren_b_i` are both 1. Words leave in write order. The removed word is on `rdata_o` after that same edge and holds until the next accepted read.
- R3: A write while `full_o` is 1 is dropped, and a read while `empty_o` is 1 is dropped; neither changes the buffer contents or order.
- R4: `empty_o` is 1 when the read domain sees no stored words. A write becomes visible to `empty_o` and `aempty_o` on the second read-clock edge after the write edge.
- R5: `full_o` is 1 when the write domain sees DEPTH stored words. A read becomes visible to `full_o` and `afull_o` on the second write-clock edge after the read edge.
- R6: After reset, `aempty_o` is 1 when the read-side word count is 7 or less, and `afull_o` is 1 when the write-side free count is 7 or less.
- R7: While `load_i` is 1, each write with both enables stores `wdata_i[7:0]` into the next threshold byte and nothing enters the buffer. The bytes are taken in this order, then the order wraps: almost-empty low, almost-empty high, almost-full low, almost-full high.
- R8: With loaded thresholds AE and AF, `aempty_o` is 1 when the read-side count is at most AE, and `afull_o` is 1 when the write-side free count is at most AF. The AE value reaches the read domain two read-clock edges after it is loaded.
- R9: Asserting `rst_ni` low empties the buffer, restores both thresholds to 7 and returns the load order to its first byte. During reset: `empty_o`=1, `aempty_o`=1, `full_o`=0, `afull_o`=0, `rvalid_o`=0 and `rdata_o`=0.
- R10: `rvalid_o` is 1 only while `oe_i` is 1 and at least one word has been read since reset. `oe_i` does not change `rdata_o`.
- R11: With unrelated write and read clocks, every stored word is read exactly once, in order, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock, may equal `wclk_i` |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wen_a_i | input | 1 | First write enable |
| wen_b_i | input | 1 | Second write enable |
| load_i | input | 1 | Routes enabled writes to the threshold registers |
| wdata_i | input | 9 | Write data; bits 7:0 carry threshold bytes |
| ren_a_i | input | 1 | First read enable |
| ren_b_i | input | 1 | Second read enable |
| oe_i | input | 1 | Output enable for the read port |
| rdata_o | output | 9 | Registered read data |
| rvalid_o | output | 1 | Read data is being presented |
| empty_o | output | 1 | No words, read domain |
| aempty_o | output | 1 | Count at or below almost-empty threshold, read domain |
| full_o | output | 1 | DEPTH words, write domain |
| afull_o | output | 1 | Free space at or below almost-full threshold, write domain |

## Verification
The bench builds the block with DEPTH set to 256. This makes it practical to fill the buffer completely, push past full, and cross both the default and the loaded thresholds from each side within a short run. In a first phase the read clock is tied to the write clock. Synchroniser latency is then a fixed two cycles, so every flag, the read data and the valid output can be predicted exactly on every cycle. A second phase runs the read clock at an unrelated period and checks ordering and completeness only.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  localparam int OFF_W = 16;
  localparam logic [OFF_W-1:0] OFF_RESET = 16'd7;

  typedef enum logic [1:0] {
    LD_AE_LO = 2'd0,
    LD_AE_HI = 2'd1,
    LD_AF_LO = 2'd2,
    LD_AF_HI = 2'd3
  } ld_step_e;

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wen_a_i,
  input  logic             wen_b_i,
  input  logic             load_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [PW-1:0]    rgray_s_i,
  output logic [PW-1:0]    wgray_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [OFF_W-1:0] ae_off_o,
  output logic             full_o,
  output logic             afull_o
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_nxt, wgray_q, rbin_s, used, space;
  logic [OFF_W-1:0] ae_off_q, af_off_q;
  ld_step_e step_q;
  logic wen, ld_fire, wr_fire;

  assign wen     = wen_a_i & wen_b_i;
  assign ld_fire = wen & load_i;
  assign wr_fire = wen & ~load_i & ~full_o;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s_i >> i);
  end

  assign used    = wbin_q - rbin_s;
  assign space   = DEPTH_P - used;
  assign full_o  = (used == DEPTH_P);
  assign afull_o = (OFF_W'(space) <= af_off_q);

  assign wbin_nxt = wbin_q + PW'(wr_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // threshold byte sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= LD_AE_LO;
      ae_off_q <= OFF_RESET;
      af_off_q <= OFF_RESET;
    end else if (ld_fire) begin
      unique case (step_q)
        LD_AE_LO: ae_off_q[7:0]  <= wdata_i[7:0];
        LD_AE_HI: ae_off_q[15:8] <= wdata_i[7:0];
        LD_AF_LO: af_off_q[7:0]  <= wdata_i[7:0];
        LD_AF_HI: af_off_q[15:8] <= wdata_i[7:0];
      endcase
      step_q <= ld_step_e'(step_q + 2'd1);
    end
  end

  assign wgray_o  = wgray_q;
  assign we_o     = wr_fire;
  assign waddr_o  = wbin_q[AW-1:0];
  assign ae_off_o = ae_off_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen && !load_i && full_o) |=> $stable(wbin_q)); // R3
  AST_LOAD_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire |=> $stable(wbin_q)); // R7
  AST_LOAD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fire && step_q == LD_AF_HI) |=> (step_q == LD_AE_LO)); // R7
  AST_USED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= DEPTH_P); // R5
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o); // R6
  AST_WGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q))); // R11

endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_a_i,
  input  logic             ren_b_i,
  input  logic             oe_i,
  input  logic [PW-1:0]    wgray_s_i,
  input  logic [OFF_W-1:0] ae_off_s_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    rgray_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             empty_o,
  output logic             aempty_o
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] rbin_q, rbin_nxt, rgray_q, wbin_s, avail;
  logic [DW-1:0] rdata_q;
  logic seen_q, ren, rd_fire;

  assign ren     = ren_a_i & ren_b_i;
  assign rd_fire = ren & ~empty_o;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s_i >> i);
  end

  assign avail    = wbin_s - rbin_q;
  assign empty_o  = (avail == '0);
  assign aempty_o = (OFF_W'(avail) <= ae_off_s_i);

  assign rbin_nxt = rbin_q + PW'(rd_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      seen_q  <= 1'b0;
    end else if (rd_fire) begin
      rdata_q <= mem_rdata_i;
      seen_q  <= 1'b1;
    end
  end

  assign raddr_o  = rbin_q[AW-1:0];
  assign rgray_o  = rgray_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = oe_i & seen_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren && empty_o) |=> $stable(rbin_q)); // R3
  AST_AVAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail <= DEPTH_P); // R4
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o); // R6
  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren |=> $stable(rdata_o)); // R2
  AST_RVALID_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !rvalid_o); // R10
  AST_RGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_q ^ $past(rgray_q))); // R11

endmodule

// File: rtl/async_fifo_thr.sv
module async_fifo_thr
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 9
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_a_i,
  input  logic          wen_b_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_a_i,
  input  logic          ren_b_i,
  input  logic          oe_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          empty_o,
  output logic          aempty_o,
  output logic          full_o,
  output logic          afull_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [OFF_W-1:0] ae_off, ae_off_s;
  logic [AW-1:0]    waddr, raddr;
  logic [DW-1:0]    mem_rdata;
  logic             we;

  fifo_wr_side #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .wen_a_i   (wen_a_i),
    .wen_b_i   (wen_b_i),
    .load_i    (load_i),
    .wdata_i   (wdata_i),
    .rgray_s_i (rgray_s),
    .wgray_o   (wgray),
    .we_o      (we),
    .waddr_o   (waddr),
    .ae_off_o  (ae_off),
    .full_o    (full_o),
    .afull_o   (afull_o)
  );

  fifo_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  fifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (wgray), .q_o (wgray_s)
  );

  fifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (rgray), .q_o (rgray_s)
  );

  // threshold is quasi-static: only changes during a load
  fifo_sync #(.W(OFF_W), .RST_VAL(OFF_RESET)) u_sync_off (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (ae_off), .q_o (ae_off_s)
  );

  fifo_rd_side #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .ren_a_i     (ren_a_i),
    .ren_b_i     (ren_b_i),
    .oe_i        (oe_i),
    .wgray_s_i   (wgray_s),
    .ae_off_s_i  (ae_off_s),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .empty_o     (empty_o),
    .aempty_o    (aempty_o)
  );

endmodule

// File: tb/tb_async_fifo_thr.sv
`timescale 1ns/1ps
module tb_async_fifo_thr;

  localparam int DEPTH = 256;

  logic wclk = 0, rclk_a = 0, tie = 1, rst_n = 0;
  logic rclk;
  logic wa = 0, wb = 0, ld = 0, ra = 0, rb = 0, oe = 0;
  logic [8:0] wd = '0;
  logic [8:0] rdata;
  logic rvalid, empty, aempty, full, afull;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 wclk = ~wclk;
  always #6.5 rclk_a = ~rclk_a;
  assign rclk = tie ? wclk : rclk_a;

  async_fifo_thr #(.DEPTH(DEPTH), .DW(9)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wen_a_i(wa), .wen_b_i(wb), .load_i(ld), .wdata_i(wd),
    .ren_a_i(ra), .ren_b_i(rb), .oe_i(oe),
    .rdata_o(rdata), .rvalid_o(rvalid), .empty_o(empty), .aempty_o(aempty),
    .full_o(full), .afull_o(afull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model, exact only while the clocks are tied
  int m_w, m_r, m_ws1, m_ws2, m_rs1, m_rs2, m_ae, m_af, m_ae1, m_ae2, m_step, m_last;
  bit m_seen;
  int q[$];

  always @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      m_w = 0; m_r = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
      m_ae = 7; m_af = 7; m_ae1 = 7; m_ae2 = 7; m_step = 0; m_last = 0; m_seen = 0;
      q.delete();
    end else if (tie) begin
      bit wf, lf, rf;
      wf = wa && wb && !ld && ((m_w - m_rs2) != DEPTH);
      lf = wa && wb && ld;
      rf = ra && rb && ((m_ws2 - m_r) != 0);
      m_rs2 = m_rs1; m_rs1 = m_r;
      m_ws2 = m_ws1; m_ws1 = m_w;
      m_ae2 = m_ae1; m_ae1 = m_ae;
      if (rf) begin m_last = q.pop_front(); m_seen = 1; m_r++; end
      if (wf) begin q.push_back(int'(wd)); m_w++; end
      if (lf) begin
        case (m_step)
          0: m_ae = (m_ae & 'hFF00) | int'(wd[7:0]);
          1: m_ae = (m_ae & 'h00FF) | (int'(wd[7:0]) << 8);
          2: m_af = (m_af & 'hFF00) | int'(wd[7:0]);
          default: m_af = (m_af & 'h00FF) | (int'(wd[7:0]) << 8);
        endcase
        m_step = (m_step + 1) % 4;
      end
    end
  end

  always @(negedge wclk) begin
    if (tie && rst_n) begin
      int ec, fc;
      ec = m_ws2 - m_r;
      fc = m_w - m_rs2;
      check(empty == (ec == 0), "R4 empty", empty, ec == 0);
      check(aempty == (ec <= m_ae2), "R6/R8 aempty", aempty, ec <= m_ae2);
      check(full == (fc == DEPTH), "R5 full", full, fc == DEPTH);
      check(afull == ((DEPTH - fc) <= m_af), "R6/R8 afull", afull, (DEPTH - fc) <= m_af);
      check(rvalid == (oe && m_seen), "R10 rvalid", rvalid, oe && m_seen);
      if (m_seen) check(int'(rdata) == m_last, "R2 rdata", rdata, m_last);
    end
  end

  task automatic drv(input bit a, input bit b, input bit l, input int d, input bit c, input bit e);
    @(posedge wclk); #2;
    wa = a; wb = b; ld = l; wd = d[8:0]; ra = c; rb = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(posedge wclk); #2;
    rst_n = 0; wa = 0; wb = 0; ld = 0; ra = 0; rb = 0;
    #1;
    check(empty == 1 && aempty == 1, "R9 empty flags in reset", {empty, aempty}, 3);
    check(full == 0 && afull == 0, "R9 full flags in reset", {full, afull}, 0);
    check(rvalid == 0 && rdata == 0, "R9 read port in reset", {rvalid, rdata}, 0);
    repeat (2) @(posedge wclk);
    #2 rst_n = 1;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge wclk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int drained;
    oe = 1;
    do_reset();
    idle(2);

    // R1: single enable writes store nothing
    drv(1, 0, 0, 'h11, 0, 0);
    drv(0, 1, 0, 'h12, 0, 0);
    drv(1, 0, 0, 'h13, 0, 0);
    idle(4);
    check(empty == 1, "R1 single-enable writes", empty, 1);

    // R2: ordered reads, single read enable ignored
    for (int i = 0; i < 10; i++) drv(1, 1, 0, 'h40 + i, 0, 0);
    idle(3);
    drv(1'b0, 1'b0, 1'b0, 0, 1, 0);
    drv(1'b0, 1'b0, 1'b0, 0, 0, 1);
    for (int i = 0; i < 10; i++) begin
      oe = (i % 3 != 1);
      drv(0, 0, 0, 0, 1, 1);
    end
    oe = 1;
    idle(3);

    // R3: read while empty then a fresh word
    for (int i = 0; i < 3; i++) drv(0, 0, 0, 0, 1, 1);
    drv(1, 1, 0, 'h1AB, 0, 0);
    idle(3);
    drv(0, 0, 0, 0, 1, 1);
    idle(2);
    check(rdata == 9'h1AB, "R3 read after underflow attempt", rdata, 'h1AB);

    // R5/R3: fill past full, then drain
    for (int i = 0; i < DEPTH + 4; i++) drv(1, 1, 0, i, 0, 0);
    idle(1);
    check(full == 1, "R5 full after DEPTH writes", full, 1);
    idle(3);
    drained = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      drv(0, 0, 0, 0, 1, 1);
      if (!empty) drained++;
    end
    idle(2);
    check(drained == DEPTH, "R3 words kept after overflow", drained, DEPTH);

    // R7: load AE=20 AF=30, fifth byte wraps to AE low = 25
    drv(1, 1, 1, 20, 0, 0);
    drv(1, 1, 1, 'h100, 0, 0);
    drv(1, 0, 1, 99, 0, 0);
    drv(1, 1, 1, 30, 0, 0);
    drv(1, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 25, 0, 0);
    idle(4);
    check(empty == 1, "R7 load writes skip buffer", empty, 1);

    // R8: thresholds
    for (int i = 0; i < 25; i++) drv(1, 1, 0, i, 0, 0);
    idle(4);
    check(aempty == 1, "R8 aempty at 25", aempty, 1);
    drv(1, 1, 0, 25, 0, 0);
    idle(4);
    check(aempty == 0, "R8 aempty at 26", aempty, 0);
    for (int i = 0; i < 199; i++) drv(1, 1, 0, i, 0, 0);
    idle(1);
    check(afull == 0, "R8 afull at free 31", afull, 0);
    drv(1, 1, 0, 7, 0, 0);
    idle(1);
    check(afull == 1, "R8 afull at free 30", afull, 1);

    // R9: reset restores defaults and load order
    do_reset();
    idle(2);
    for (int i = 0; i < 7; i++) drv(1, 1, 0, i, 0, 0);
    idle(4);
    check(aempty == 1, "R9 default AE at 7", aempty, 1);
    drv(1, 1, 0, 7, 0, 0);
    idle(4);
    check(aempty == 0, "R9 default AE at 8", aempty, 0);
    for (int i = 0; i < 8; i++) drv(0, 0, 0, 0, 1, 1);
    idle(3);
    drv(1, 1, 1, 2, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, i, 0, 0);
    idle(4);
    check(aempty == 0, "R9 load order restarts at AE low", aempty, 0);

    // R11: unrelated clocks
    tie = 0;
    do_reset();
    begin
      int exp_q[$];
      int got;
      got = 0;
      fork
        begin
          int n;
          n = 0;
          while (n < 600) begin
            @(posedge wclk); #2;
            if (!full && ($urandom % 4 != 0)) begin
              wa = 1; wb = 1; wd = 9'((n * 7) % 512);
              exp_q.push_back((n * 7) % 512);
              n++;
            end else begin
              wa = 0; wb = 0;
            end
          end
          @(posedge wclk); #2; wa = 0; wb = 0;
        end
        begin
          bit pend;
          pend = 0;
          while (got < 600) begin
            @(posedge rclk); #1;
            if (pend) begin
              int e;
              e = exp_q.pop_front();
              check(int'(rdata) == e, "R11 data order", rdata, e);
              got++;
            end
            pend = 0;
            if (got < 600 && !empty && ($urandom % 3 != 0)) begin
              ra = 1; rb = 1; pend = (got + 1 <= 600);
            end else begin
              ra = 0; rb = 0;
            end
          end
          ra = 0; rb = 0;
        end
      join
      repeat (6) @(posedge rclk);
      #1;
      check(got == 600 && exp_q.size() == 0, "R11 word count", got, 600);
      check(empty == 1, "R11 empty after drain", empty, 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule